// File: doc/BRIEF.md
# Multi-Channel Double-Edge PWM Timer

A pulse width modulator built around one prescaled period counter that drives six outputs. Each output has its own programmed turn-on and turn-off count. It is high while the counter lies at or above the turn-on count and below the turn-off count. The counter runs continuously or for one period only. It can be started by a write, or, in follower mode, by a sync pulse from another instance. It emits its own sync pulse at a programmed count so that further instances can follow it.

A trap input overrides all six outputs with a software-chosen pattern until software releases it. Three capture pins snapshot the counter on a selectable edge. A per-output carrier gate ANDs an output with an external carrier. A sticky flag register with per-bit enables collects turn-on and turn-off events, captures, wrap and trap, and drives one interrupt line. Configuration uses a plain single-cycle write port (`wr_en`, `wr_addr`, `wr_data`). It has no handshake and no back-pressure, and every write lands on the clock edge where `wr_en` is high. No port of the block carries a data stream, so there is no valid/ready interface.

Register addresses: 0 control (bit0 run, bit1 single-period, bit2 follower), 1 prescale, 2 period, 3 sync count, 4 trap pattern, 5 trap release (any data), 6 interrupt enables, 7 flag clear (write-1), 8 capture edge select, 9 carrier gate mask, 16+2i turn-on count of output i, 17+2i turn-off count of output i.

Top module: `dpwm_timer`

## Requirements
- R1: While running, the counter advances by one every (prescale+1) clocks. After the tick on which it equals the period value it returns to 0. A control write restarts it at 0 with the prescaler cleared, and bit0 of that write sets whether it runs.
- R2: Output i is high exactly when running and turn-on ≤ count < turn-off. Equal counts keep it low. A turn-off count above the period keeps it high from turn-on until the wrap.
- R3: Writes to prescale, period, sync count and the per-output counts are held in buffers. They take effect at the wrap, at a restart, or at once while stopped. An output never changes shape in the middle of a period.
- R4: In single-period mode (control bit1) the counter stops at 0 after its wrap, all outputs go low, and the count stays frozen until the next restart.
- R5: While `trap_in` is high at a clock edge, the trap latches. From the next cycle `pwm_out` equals the trap pattern (bit i to output i) and stays so after `trap_in` falls, until a write to address 5. The trap flag is set only when the trap newly latches.
- R6: Capture j stores the count present at the edge where its pin shows the selected transition. Edge select bits 2j+1:2j are 01 for rising, 10 for falling and 11 for both. A transition that is not selected leaves the stored value unchanged. The stored values are packed at `cap_data[16j+15:16j]`.
- R7: Flag layout: bit 2i is the output i turn-on event (tick moving the count to turn-on), bit 2i+1 the turn-off event, bits 12+j capture j, bit 15 wrap, bit 16 trap. Flags are sticky and cleared by writing 1 to address 7. When a clear and a new event for the same bit fall in the same cycle, the bit stays set.
- R8: `irq` is high exactly when some flag is set whose enable bit (address 6, same layout) is set.
- R9: An output whose bit is set in the carrier gate mask is driven as its PWM level AND `carrier_in`. Other outputs ignore the carrier.
- R10: `sync_out` is high for the one clock on which the prescaler ticks while the count equals the sync count.
- R11: With follower mode set, a high `sync_in` at a clock edge restarts the counter at 0 and sets it running.
- R12: After reset the outputs, count, captures, flags and `irq` are all 0, and the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 32 | Register write data |
| trap_in | input | 1 | Trap request, level sampled |
| cap_in | input | 3 | Capture pins |
| carrier_in | input | 1 | External carrier for gated outputs |
| sync_in | input | 1 | Start pulse from a leading instance |
| pwm_out | output | 6 | PWM outputs |
| sync_out | output | 1 | Sync pulse for following instances |
| count_out | output | 16 | Current period count |
| cap_data | output | 48 | Three packed capture values |
| irq_flags | output | 17 | Sticky event flags |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a flag clear that lands on the very edge where the same flag is raised again. The bench tracks the period phase from the known restart cycle. It waits until the count sits at the period value and then issues the wrap-flag clear, so that the write and the wrap share one edge. A second case is buffered counts that are written mid-period. These are checked across the next wrap against old and new output shapes.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;
  localparam int A_CTRL    = 0;
  localparam int A_PRESC   = 1;
  localparam int A_PERIOD  = 2;
  localparam int A_SYNC    = 3;
  localparam int A_TRAPPAT = 4;
  localparam int A_TRAPREL = 5;
  localparam int A_IRQEN   = 6;
  localparam int A_IRQCLR  = 7;
  localparam int A_CAPSEL  = 8;
  localparam int A_GATE    = 9;
  localparam int A_CHBASE  = 16;
  localparam int CTL_RUN    = 0;
  localparam int CTL_ONCE   = 1;
  localparam int CTL_FOLLOW = 2;
endpackage

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run_val,
  input  logic          once,
  input  logic [CW-1:0] presc_b,
  input  logic [CW-1:0] period_b,
  input  logic [CW-1:0] sync_b,
  output logic          running,
  output logic          tick,
  output logic          wrap,
  output logic          load,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_next,
  output logic          sync_pulse
);
  logic [CW-1:0] presc_a, period_a, sync_a, pcnt;

  assign tick       = running && (pcnt == presc_a);
  assign wrap       = tick && (cnt == period_a);
  assign cnt_next   = wrap ? '0 : cnt + 1'b1;
  assign load       = !running || wrap || restart;
  assign sync_pulse = tick && (cnt == sync_a);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_a  <= '0;
      period_a <= '0;
      sync_a   <= '0;
      pcnt     <= '0;
      cnt      <= '0;
      running  <= 1'b0;
    end else begin
      if (load) begin
        presc_a  <= presc_b;
        period_a <= period_b;
        sync_a   <= sync_b;
      end
      if (restart) begin
        running <= run_val;
        cnt     <= '0;
        pcnt    <= '0;
      end else if (running) begin
        pcnt <= tick ? '0 : pcnt + 1'b1;
        if (tick) begin
          cnt <= cnt_next;
          if (wrap && once) running <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pwm_edge_channel.sv
module pwm_edge_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          tick,
  input  logic          running,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cnt_next,
  input  logic [CW-1:0] on_b,
  input  logic [CW-1:0] off_b,
  output logic          level,
  output logic          ev_on,
  output logic          ev_off
);
  logic [CW-1:0] on_a, off_a;

  assign level  = running && (cnt >= on_a) && (cnt < off_a);
  assign ev_on  = tick && (cnt_next == on_a);
  assign ev_off = tick && (cnt_next == off_a);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_a  <= '0;
      off_a <= '0;
    end else if (load) begin
      on_a  <= on_b;
      off_a <= off_b;
    end
  end
endmodule

// File: rtl/pwm_capture.sv
module pwm_capture #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic [1:0]    edge_sel,
  input  logic [CW-1:0] cnt,
  output logic [CW-1:0] value,
  output logic          event_o
);
  logic prev;

  assign event_o = (pin && !prev && edge_sel[0]) || (!pin && prev && edge_sel[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev  <= 1'b0;
      value <= '0;
    end else begin
      prev <= pin;
      if (event_o) value <= cnt;
    end
  end
endmodule

// File: rtl/dpwm_timer.sv
module dpwm_timer
  import pwm_pkg::*;
#(
  parameter int NCH  = 6,
  parameter int NCAP = 3,
  parameter int CW   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [4:0]                 wr_addr,
  input  logic [31:0]                wr_data,
  input  logic                       trap_in,
  input  logic [NCAP-1:0]            cap_in,
  input  logic                       carrier_in,
  input  logic                       sync_in,
  output logic [NCH-1:0]             pwm_out,
  output logic                       sync_out,
  output logic [CW-1:0]              count_out,
  output logic [NCAP*CW-1:0]         cap_data,
  output logic [2*NCH+NCAP+1:0]      irq_flags,
  output logic                       irq
);
  localparam int NFLAG    = 2*NCH + NCAP + 2;
  localparam int CAP_BIT  = 2*NCH;
  localparam int WRAP_BIT = 2*NCH + NCAP;
  localparam int TRAP_BIT = WRAP_BIT + 1;

  logic [2:0]        ctrl_q;
  logic [CW-1:0]     presc_b, period_b, sync_b;
  logic [NCH-1:0]    trap_pat_q, gate_q;
  logic [NFLAG-1:0]  irq_en_q, flags_q, events, clr_mask;
  logic [2*NCAP-1:0] cap_sel_q;
  logic [CW-1:0]     on_b  [NCH];
  logic [CW-1:0]     off_b [NCH];
  logic              trap_q, trap_new;
  logic              restart_w, run_val_w, run_w, tick_w, wrap_w, load_w;
  logic [CW-1:0]     cnt_w, cnt_next_w;
  logic [NCH-1:0]    level_w, ev_on_w, ev_off_w;
  logic [NCAP-1:0]   cap_ev_w;

  function automatic logic hit(input logic [4:0] a, input int target);
    return wr_en && (a == ADDR_W'(target));
  endfunction

  assign restart_w = hit(wr_addr, A_CTRL) || (ctrl_q[CTL_FOLLOW] && sync_in);
  assign run_val_w = hit(wr_addr, A_CTRL) ? wr_data[CTL_RUN] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      presc_b    <= '0;
      period_b   <= '0;
      sync_b     <= '0;
      trap_pat_q <= '0;
      gate_q     <= '0;
      irq_en_q   <= '0;
      cap_sel_q  <= '0;
    end else begin
      if (hit(wr_addr, A_CTRL))    ctrl_q     <= wr_data[2:0];
      if (hit(wr_addr, A_PRESC))   presc_b    <= wr_data[CW-1:0];
      if (hit(wr_addr, A_PERIOD))  period_b   <= wr_data[CW-1:0];
      if (hit(wr_addr, A_SYNC))    sync_b     <= wr_data[CW-1:0];
      if (hit(wr_addr, A_TRAPPAT)) trap_pat_q <= wr_data[NCH-1:0];
      if (hit(wr_addr, A_GATE))    gate_q     <= wr_data[NCH-1:0];
      if (hit(wr_addr, A_IRQEN))   irq_en_q   <= wr_data[NFLAG-1:0];
      if (hit(wr_addr, A_CAPSEL))  cap_sel_q  <= wr_data[2*NCAP-1:0];
    end
  end

  pwm_period_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart_w), .run_val(run_val_w),
    .once(ctrl_q[CTL_ONCE]), .presc_b(presc_b), .period_b(period_b), .sync_b(sync_b),
    .running(run_w), .tick(tick_w), .wrap(wrap_w), .load(load_w),
    .cnt(cnt_w), .cnt_next(cnt_next_w), .sync_pulse(sync_out)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        on_b[i]  <= '0;
        off_b[i] <= '0;
      end else begin
        if (hit(wr_addr, A_CHBASE + 2*i))     on_b[i]  <= wr_data[CW-1:0];
        if (hit(wr_addr, A_CHBASE + 2*i + 1)) off_b[i] <= wr_data[CW-1:0];
      end
    end

    pwm_edge_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .load(load_w), .tick(tick_w), .running(run_w),
      .cnt(cnt_w), .cnt_next(cnt_next_w), .on_b(on_b[i]), .off_b(off_b[i]),
      .level(level_w[i]), .ev_on(ev_on_w[i]), .ev_off(ev_off_w[i])
    );

    assign pwm_out[i]      = trap_q ? trap_pat_q[i] : (level_w[i] && (!gate_q[i] || carrier_in));
    assign events[2*i]     = ev_on_w[i];
    assign events[2*i + 1] = ev_off_w[i];
  end

  for (genvar j = 0; j < NCAP; j++) begin : g_cap
    pwm_capture #(.CW(CW)) u_cap (
      .clk(clk), .rst_n(rst_n), .pin(cap_in[j]), .edge_sel(cap_sel_q[2*j +: 2]),
      .cnt(cnt_w), .value(cap_data[CW*j +: CW]), .event_o(cap_ev_w[j])
    );
    assign events[CAP_BIT + j] = cap_ev_w[j];
  end

  assign trap_new           = trap_in && !trap_q;
  assign events[WRAP_BIT]   = wrap_w;
  assign events[TRAP_BIT]   = trap_new;
  assign clr_mask           = hit(wr_addr, A_IRQCLR) ? wr_data[NFLAG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_q  <= 1'b0;
      flags_q <= '0;
    end else begin
      if (trap_in)                       trap_q <= 1'b1;
      else if (hit(wr_addr, A_TRAPREL))  trap_q <= 1'b0;
      flags_q <= (flags_q & ~clr_mask) | events;
    end
  end

  assign count_out = cnt_w;
  assign irq_flags = flags_q;
  assign irq       = |(flags_q & irq_en_q);
endmodule

// File: rtl/dpwm_timer_chk.sv
module dpwm_timer_chk #(
  parameter int NCH  = 6,
  parameter int NCAP = 3,
  parameter int CW   = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [4:0]            wr_addr,
  input logic [31:0]           wr_data,
  input logic                  trap_in,
  input logic [NCH-1:0]        pwm_out,
  input logic [NCH-1:0]        trap_pat,
  input logic [CW-1:0]         count_out,
  input logic                  running,
  input logic                  restart,
  input logic [NCAP*CW-1:0]    cap_data,
  input logic [2*NCH+NCAP+1:0] irq_flags,
  input logic                  irq
);
  localparam int NFLAG = 2*NCH + NCAP + 2;
  logic [NFLAG-1:0] last_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) last_clr <= '0;
    else last_clr <= (wr_en && wr_addr == 5'd7) ? wr_data[NFLAG-1:0] : '0;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !restart) |=> (count_out == $past(count_out) || count_out == CW'($past(count_out) + 1) || count_out == '0)); // R1
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !restart) |=> $stable(count_out)); // R4
  AST_TRAP_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    trap_in |=> (pwm_out == trap_pat)); // R5
  AST_CAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_data[CW-1:0]) |-> irq_flags[2*NCH]); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(irq_flags) & ~irq_flags & ~last_clr) == '0)); // R7
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_flags != '0)); // R8
endmodule

bind dpwm_timer dpwm_timer_chk #(.NCH(NCH), .NCAP(NCAP), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .trap_in(trap_in), .pwm_out(pwm_out), .trap_pat(trap_pat_q), .count_out(count_out),
  .running(run_w), .restart(restart_w), .cap_data(cap_data), .irq_flags(irq_flags), .irq(irq)
);

// File: tb/dpwm_timer_bench.sv
module dpwm_timer_bench;
  localparam int CLK_NS = 8;
  localparam int PER = 9;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, trap_in = 1'b0, carrier_in = 1'b0, sync_in = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] cap_in = '0;
  logic [5:0] pwm_out;
  logic sync_out, irq;
  logic [15:0] count_out;
  logic [47:0] cap_data;
  logic [16:0] irq_flags;

  dpwm_timer u_dpwm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trap_in(trap_in), .cap_in(cap_in), .carrier_in(carrier_in), .sync_in(sync_in),
    .pwm_out(pwm_out), .sync_out(sync_out), .count_out(count_out), .cap_data(cap_data),
    .irq_flags(irq_flags), .irq(irq)
  );

  always #(CLK_NS/2) clk = ~clk;

  typedef struct {
    int          cyc;
    int          kind;
    logic [63:0] mask;
    logic [63:0] exp;
    int          req;
  } item_t;

  item_t q[$];
  int cyc = 0, checks = 0, errors = 0, base = 0, ph = 0, s0 = 0;
  bit done = 0;

  // kinds: 0 pwm, 1 count, 2 sync, 3 capture, 4 flags, 5 irq
  task automatic expect_at(input int c, input int kind, input logic [63:0] mask,
                           input logic [63:0] exp, input int req);
    item_t it;
    it.cyc = c; it.kind = kind; it.mask = mask; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wr_addr = a[4:0]; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [5:0] lvl(input int k, input int on0, input int off0);
    logic [5:0] v = '0;
    v[0] = (k >= on0) && (k < off0);
    v[2] = (k >= 7);
    return v;
  endfunction

  function automatic int phase();
    return (cyc - base) % (PER + 1);
  endfunction

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #3;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].cyc == cyc) begin
          logic [63:0] act;
          case (q[i].kind)
            0: act = 64'(pwm_out);
            1: act = 64'(count_out);
            2: act = 64'(sync_out);
            3: act = 64'(cap_data);
            4: act = 64'(irq_flags);
            default: act = 64'(irq);
          endcase
          checks++;
          if ((act & q[i].mask) != (q[i].exp & q[i].mask)) begin
            errors++;
            $display("FAIL R%0d kind %0d cycle %0d: actual %0h expected %0h",
                     q[i].req, q[i].kind, cyc, act & q[i].mask, q[i].exp & q[i].mask);
          end
          q.delete(i);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    expect_at(cyc + 1, 0, 64'h3F, 0, 12);
    expect_at(cyc + 1, 1, 64'hFFFF, 0, 12);
    expect_at(cyc + 1, 3, '1, 0, 12);
    expect_at(cyc + 1, 4, 64'h1FFFF, 0, 12);
    expect_at(cyc + 1, 5, 1, 0, 12);
    repeat (2) @(negedge clk);

    wr(2, PER); wr(1, 0); wr(3, 4);
    wr(16, 2); wr(17, 5); wr(18, 3); wr(19, 3); wr(20, 7); wr(21, 20);
    wr(6, 32'h1_0000);
    wr(0, 1);
    base = cyc;
    // R1 R2 continuous counting and shapes
    for (int k = 1; k <= 20; k++) begin
      expect_at(base + k, 1, 64'hFFFF, k % (PER + 1), 1);
      expect_at(base + k, 0, 64'h3F, lvl(k % (PER + 1), 2, 5), 2);
    end
    expect_at(base + 4, 2, 1, 1, 10);    // R10 sync at count 4
    expect_at(base + 5, 2, 1, 0, 10);
    expect_at(base + 14, 2, 1, 1, 10);
    expect_at(base + 1, 4, 64'h1, 0, 7); // R7 turn-on flag of output 0
    expect_at(base + 2, 4, 64'h1, 1, 7);
    expect_at(base + 9, 4, 64'h8000, 0, 7);
    expect_at(base + 10, 4, 64'h8000, 64'h8000, 7);
    repeat (21) @(negedge clk);

    // R3 buffered counts written mid-period
    while (phase() != 1) @(negedge clk);
    wr(16, 6); wr(17, 8);
    ph = phase();
    for (int j = 1; j <= 15; j++) begin
      if (ph + j >= PER + 1) expect_at(cyc + j, 0, 64'h3F, lvl((ph + j) % (PER + 1), 6, 8), 3);
      else                   expect_at(cyc + j, 0, 64'h3F, lvl((ph + j) % (PER + 1), 2, 5), 3);
    end
    repeat (16) @(negedge clk);

    // R5 trap
    wr(4, 32'h2A);
    trap_in = 1'b1;
    expect_at(cyc + 1, 0, 64'h3F, 64'h2A, 5);
    expect_at(cyc + 1, 4, 64'h10000, 64'h10000, 5);
    expect_at(cyc + 1, 5, 1, 1, 8); // R8
    @(negedge clk);
    trap_in = 1'b0;
    expect_at(cyc + 4, 0, 64'h3F, 64'h2A, 5);
    repeat (5) @(negedge clk);
    expect_at(cyc + 1, 0, 64'h3F, lvl((cyc + 1 - base) % (PER + 1), 6, 8), 5);
    wr(5, 0);
    expect_at(cyc + 1, 5, 1, 0, 8);
    expect_at(cyc + 1, 4, 64'h10000, 0, 7);
    wr(7, 32'h1_0000);

    // R7 clear on the same edge as a wrap: event wins
    while (phase() != PER) @(negedge clk);
    expect_at(cyc + 1, 4, 64'h8000, 64'h8000, 7);
    wr(7, 32'h8000);
    while (phase() != 3) @(negedge clk);
    expect_at(cyc + 1, 4, 64'h8000, 0, 7);
    wr(7, 32'h8000);

    // R9 carrier gate on output 2
    wr(9, 32'h4);
    carrier_in = 1'b0;
    while (phase() != 7) @(negedge clk);
    expect_at(cyc + 1, 0, 64'h4, 0, 9);
    @(negedge clk);
    carrier_in = 1'b1;
    expect_at(cyc + 1, 0, 64'h4, 64'h4, 9);
    @(negedge clk);
    wr(9, 0);

    // R6 captures: pin 0 rising, pin 1 falling
    wr(8, 32'h9);
    while (phase() != 4) @(negedge clk);
    cap_in[0] = 1'b1;
    expect_at(cyc + 1, 3, 64'hFFFF, 4, 6);
    expect_at(cyc + 1, 4, 64'h1000, 64'h1000, 6);
    repeat (2) @(negedge clk);
    cap_in[0] = 1'b0;
    expect_at(cyc + 2, 3, 64'hFFFF, 4, 6);
    repeat (2) @(negedge clk);
    cap_in[1] = 1'b1;
    expect_at(cyc + 1, 3, 64'hFFFF_0000, 0, 6);
    @(negedge clk);
    cap_in[1] = 1'b0;
    expect_at(cyc + 1, 3, 64'hFFFF_0000, 64'(phase()) << 16, 6);
    repeat (2) @(negedge clk);

    // R4 single period
    wr(0, 3);
    base = cyc;
    for (int k = 1; k <= 14; k++) begin
      expect_at(base + k, 1, 64'hFFFF, (k <= PER) ? k : 0, 4);
      expect_at(base + k, 0, 64'h3F, (k <= PER) ? lvl(k, 6, 8) : 6'h0, 4);
    end
    repeat (15) @(negedge clk);

    // R11 follower start, with R1 prescale of 2
    wr(1, 2);
    wr(0, 4);
    expect_at(cyc + 3, 1, 64'hFFFF, 0, 11);
    repeat (4) @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    s0 = cyc;
    expect_at(s0 + 2, 1, 64'hFFFF, 0, 1);
    expect_at(s0 + 3, 1, 64'hFFFF, 1, 11);
    expect_at(s0 + 5, 1, 64'hFFFF, 1, 1);
    expect_at(s0 + 6, 1, 64'hFFFF, 2, 1);
    repeat (8) @(negedge clk);

    if (q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL %0d expectations never sampled", q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule